// File: doc/BRIEF.md
# Two-Wire Bus Snooping Router

This block listens to a two-wire host control bus (clock and data, open-drain style) and decides which of three downstream targets the bus is connected to: an external configuration PROM, a display DDC port, or the block's own internal register target. It does not drive the bus. It samples both bus lines with a fast system clock, detects START and STOP conditions, and deserializes the bytes of each transaction. From these it moves a sticky route selector. The selector is shown as three one-hot enables and a 2-bit status code.

The route does not follow each transaction. After reset the bus goes to the PROM. Any transaction whose address byte names the internal device takes the bus over for the internal registers at once. Once there, a command byte written to the internal device asks for the PROM or the DDC, and the change is applied at the next STOP. While the DDC is selected, the only way back is a START followed by a STOP, which returns the route to the internal registers. The internal register target is modelled by its enable and by the captured command byte, which is given out with a one-cycle strobe.

Top module: `twbus_snoop_router`

## Requirements
- R1: While reset is asserted and on the first cycles after it is released, the PROM enable is high and the route status reads 0.
- R2: Exactly one of the three enables is high at any time. The status code is 0 for PROM, 1 for internal registers and 2 for DDC.
- R3: While routed to the PROM, a transaction whose first byte carries the internal device address switches the route to internal registers when that byte completes, before any STOP.
- R4: The device address byte is 72h (bits 7..1 = 0111001) when `addr_sel` is low and 70h (bits 7..1 = 0111000) when `addr_sel` is high. Bit 0 (read/write) is not compared.
- R5: While routed to the PROM, a transaction to any other address leaves the route unchanged.
- R6: While routed to internal registers, a write transaction (address bit 0 = 0) to the device whose second byte equals `CMD_TO_PROM` (default 01h) or `CMD_TO_DDC` (default 02h) moves the route to the PROM or the DDC. The change is applied only at the following STOP, and the route is unchanged before that STOP.
- R7: Any other command value, any second byte of a read transaction, and any byte sent to another address leave the route unchanged.
- R8: While routed to the DDC, address bytes are not decoded. A START followed later by a STOP returns the route to internal registers. A STOP that has no START since the DDC was entered leaves the route on the DDC.
- R9: START is a falling data edge and STOP a rising data edge while the clock is high. Data edges while the clock is low are not events. A repeated START does not apply a pending route change.
- R10: The second byte of each write transaction to the device, taken while routed to internal registers, is presented on `reg_opcode` and held until the next such byte, with `reg_opcode_vld` pulsing for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_scl | input | 1 | Host bus clock line as seen at the pad |
| bus_sda | input | 1 | Host bus data line as seen at the pad |
| addr_sel | input | 1 | Address select strap: low gives 72h, high gives 70h |
| en_prom | output | 1 | Route enable for the PROM path |
| en_reg | output | 1 | Route enable for the internal register target |
| en_ddc | output | 1 | Route enable for the DDC path |
| route_status | output | 2 | Current route: 0 PROM, 1 registers, 2 DDC |
| reg_opcode | output | 8 | Last command byte captured for the register target |
| reg_opcode_vld | output | 1 | One-cycle strobe when `reg_opcode` is updated |

## Verification
The bench builds the block with a three-stage synchronizer, so it runs on a different depth from the two-stage default. The default device base and command codes are kept, so both settings of `addr_sel` and both command codes are exercised against their documented byte values. The bus is toggled slowly enough that every state can be checked in the middle of a transaction, between the last byte and its STOP, as well as after the STOP. This shows that a hijack happens at once while an opcode-driven change waits for the STOP, and it covers the DDC exit with a lone STOP and with a START+STOP pair.

// File: rtl/twr_pkg.sv
package twr_pkg;
   typedef enum logic [1:0] {
      RT_PROM = 2'd0,
      RT_REG  = 2'd1,
      RT_DDC  = 2'd2
   } route_e;

   localparam int ROUTE_COUNT = 3;
   localparam int BYTE_W      = 8;
endpackage

// File: rtl/twr_line_watch.sv
module twr_line_watch #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_o,
   output logic start_o,
   output logic stop_o,
   output logic rise_o
);
   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_q, sda_q, scl_p, sda_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_q;
         sda_p  <= sda_q;
      end
   end

   assign scl_q   = scl_ff[STAGES-1];
   assign sda_q   = sda_ff[STAGES-1];
   assign sda_o   = sda_q;
   assign start_o = scl_q & scl_p &  sda_p & ~sda_q;
   assign stop_o  = scl_q & scl_p & ~sda_p &  sda_q;
   assign rise_o  = scl_q & ~scl_p;
endmodule

// File: rtl/twr_byte_shift.sv
module twr_byte_shift #(
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              rise_i,
   input  logic              sda_i,
   output logic              done_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int CNT_W   = $clog2(BYTE_W + 1);
   localparam int ACK_POS = BYTE_W;
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   logic              active;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         bit_cnt <= '0;
         shreg   <= '0;
         idx     <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            active  <= 1'b1;
            bit_cnt <= '0;
            idx     <= '0;
         end else if (stop_i) begin
            active  <= 1'b0;
         end else if (active && rise_i) begin
            if (bit_cnt == CNT_W'(ACK_POS)) begin
               bit_cnt <= '0;
               if (idx != IDX_MAX) idx <= idx + 1'b1;
            end else begin
               shreg   <= {shreg[BYTE_W-2:0], sda_i};
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == CNT_W'(ACK_POS - 1)) done_o <= 1'b1;
            end
         end
      end
   end

   assign byte_o = shreg;
   assign idx_o  = idx;
endmodule

// File: rtl/twr_route_ctl.sv
module twr_route_ctl
   import twr_pkg::*;
#(
   parameter int          IDX_W       = 2,
   parameter logic [6:0]  DEV_BASE    = 7'h38,
   parameter logic [7:0]  CMD_TO_PROM = 8'h01,
   parameter logic [7:0]  CMD_TO_DDC  = 8'h02
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             done_i,
   input  logic [7:0]       byte_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic             addr_sel,
   output route_e           route_o,
   output logic [7:0]       opcode_o,
   output logic             opcode_vld_o
);
   route_e route;
   route_e pend_rt;
   logic   pend;
   logic   addr_hit;
   logic   ddc_seen;
   logic   addr_match;
   logic   is_addr_byte;
   logic   is_cmd_byte;

   assign addr_match   = (byte_i[7:1] == {DEV_BASE[6:1], ~addr_sel});
   assign is_addr_byte = done_i && (idx_i == '0);
   assign is_cmd_byte  = done_i && (idx_i == IDX_W'(1)) && addr_hit && (route == RT_REG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route        <= RT_PROM;
         pend_rt      <= RT_REG;
         pend         <= 1'b0;
         addr_hit     <= 1'b0;
         ddc_seen     <= 1'b0;
         opcode_o     <= '0;
         opcode_vld_o <= 1'b0;
      end else begin
         opcode_vld_o <= 1'b0;
         if (start_i) begin
            addr_hit <= 1'b0;
            if (route == RT_DDC) ddc_seen <= 1'b1;
         end else if (stop_i) begin
            addr_hit <= 1'b0;
            pend     <= 1'b0;
            if (route == RT_DDC) begin
               if (ddc_seen) begin
                  route    <= RT_REG;
                  ddc_seen <= 1'b0;
               end
            end else if (pend) begin
               route    <= pend_rt;
               ddc_seen <= 1'b0;
            end
         end else if (is_addr_byte) begin
            if (route != RT_DDC) begin
               addr_hit <= addr_match & ~byte_i[0];
               if (route == RT_PROM && addr_match) route <= RT_REG;
            end
         end else if (is_cmd_byte) begin
            opcode_o     <= byte_i;
            opcode_vld_o <= 1'b1;
            if (byte_i == CMD_TO_PROM) begin
               pend    <= 1'b1;
               pend_rt <= RT_PROM;
            end else if (byte_i == CMD_TO_DDC) begin
               pend    <= 1'b1;
               pend_rt <= RT_DDC;
            end
         end
      end
   end

   assign route_o = route;
endmodule

// File: rtl/twbus_snoop_router.sv
module twbus_snoop_router
   import twr_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         IDX_W       = 2,
   parameter logic [6:0] DEV_BASE    = 7'h38,
   parameter logic [7:0] CMD_TO_PROM = 8'h01,
   parameter logic [7:0] CMD_TO_DDC  = 8'h02
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_scl,
   input  logic       bus_sda,
   input  logic       addr_sel,
   output logic       en_prom,
   output logic       en_reg,
   output logic       en_ddc,
   output logic [1:0] route_status,
   output logic [7:0] reg_opcode,
   output logic       reg_opcode_vld
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must be at least 1");
   end
   if (CMD_TO_PROM == CMD_TO_DDC) begin : g_bad_cmd
      $error("command codes must differ");
   end

   logic              sda_s, start_evt, stop_evt, rise_evt, byte_evt;
   logic [BYTE_W-1:0] byte_val;
   logic [IDX_W-1:0]  byte_idx;
   route_e            route;
   logic [ROUTE_COUNT-1:0] en_vec;

   twr_line_watch #(.STAGES(SYNC_STAGES)) i_watch (
      .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(bus_sda),
      .sda_o(sda_s), .start_o(start_evt), .stop_o(stop_evt), .rise_o(rise_evt)
   );

   twr_byte_shift #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) i_shift (
      .clk(clk), .rst_n(rst_n), .start_i(start_evt), .stop_i(stop_evt),
      .rise_i(rise_evt), .sda_i(sda_s), .done_o(byte_evt),
      .byte_o(byte_val), .idx_o(byte_idx)
   );

   twr_route_ctl #(
      .IDX_W(IDX_W), .DEV_BASE(DEV_BASE),
      .CMD_TO_PROM(CMD_TO_PROM), .CMD_TO_DDC(CMD_TO_DDC)
   ) i_ctl (
      .clk(clk), .rst_n(rst_n), .start_i(start_evt), .stop_i(stop_evt),
      .done_i(byte_evt), .byte_i(byte_val), .idx_i(byte_idx),
      .addr_sel(addr_sel), .route_o(route), .opcode_o(reg_opcode),
      .opcode_vld_o(reg_opcode_vld)
   );

   for (genvar i = 0; i < ROUTE_COUNT; i++) begin : g_en
      assign en_vec[i] = (route == route_e'(i));
   end

   assign en_prom      = en_vec[RT_PROM];
   assign en_reg       = en_vec[RT_REG];
   assign en_ddc       = en_vec[RT_DDC];
   assign route_status = route;
endmodule

// File: rtl/twr_router_chk.sv
module twr_router_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       en_prom,
   input logic       en_reg,
   input logic       en_ddc,
   input logic [1:0] route_status,
   input logic       stop_evt,
   input logic       byte_evt
);
   assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (en_prom && route_status == 2'd0));

   assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({en_prom, en_reg, en_ddc}));

   assert_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en_ddc |-> route_status == 2'd2) and (en_reg |-> route_status == 2'd1));

   assert_hijack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_prom) |-> (en_reg && $past(byte_evt)));

   assert_ddc_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_ddc) |-> ($past(stop_evt) && $past(en_reg)));

   assert_prom_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_prom) |-> ($past(stop_evt) && $past(en_reg)));

   assert_ddc_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_ddc) |-> (en_reg && $past(stop_evt)));
endmodule

bind twbus_snoop_router twr_router_chk i_chk (
   .clk(clk), .rst_n(rst_n), .en_prom(en_prom), .en_reg(en_reg),
   .en_ddc(en_ddc), .route_status(route_status),
   .stop_evt(stop_evt), .byte_evt(byte_evt)
);

// File: tb/test_twbus_snoop_router.sv
module test_twbus_snoop_router;
   localparam int HALF = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1, sda = 1'b1, addr_sel = 1'b0;
   logic       en_prom, en_reg, en_ddc, opc_vld;
   logic [1:0] status;
   logic [7:0] opc;
   int         n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   twbus_snoop_router #(.SYNC_STAGES(3)) i_twbus_snoop_router (
      .clk(clk), .rst_n(rst_n), .bus_scl(scl), .bus_sda(sda),
      .addr_sel(addr_sel), .en_prom(en_prom), .en_reg(en_reg),
      .en_ddc(en_ddc), .route_status(status), .reg_opcode(opc),
      .reg_opcode_vld(opc_vld)
   );

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_route(input string req, input logic [1:0] exp);
      logic [2:0] exp_en, act_en;
      exp_en = (exp == 2'd0) ? 3'b100 : (exp == 2'd1) ? 3'b010 : 3'b001;
      act_en = {en_prom, en_reg, en_ddc};
      n_run++;
      if (status !== exp || act_en !== exp_en) begin
         n_fail++;
         $display("FAIL %s: status=%0d en=%b expected status=%0d en=%b",
                  req, status, act_en, exp, exp_en);
      end
   endtask

   task automatic chk_val(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic b_start();
      sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF);
      sda = 1'b0; wt(HALF); scl = 1'b0; wt(HALF);
   endtask

   task automatic b_stop();
      sda = 1'b0; wt(HALF); scl = 1'b1; wt(HALF);
      sda = 1'b1; wt(2*HALF);
   endtask

   task automatic b_bit(input logic v);
      sda = v; wt(HALF); scl = 1'b1; wt(HALF); scl = 1'b0; wt(HALF);
   endtask

   task automatic b_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) b_bit(v[i]);
      b_bit(1'b0);
   endtask

   task automatic t_reset();
      wt(4);
      chk_route("R1 during reset", 2'd0);
      rst_n = 1'b1; wt(3);
      chk_route("R1 after reset", 2'd0);
      chk_route("R2 reset code", 2'd0);
   endtask

   task automatic t_foreign();
      b_start(); b_byte(8'hA0); b_byte(8'h72); b_stop();
      chk_route("R5 foreign address", 2'd0);
      b_start(); b_byte(8'h70); b_byte(8'h02); b_stop();
      chk_route("R4 70h with sel low", 2'd0);
   endtask

   task automatic t_hijack();
      b_start(); b_byte(8'h73);
      chk_route("R3 R4 hijack on read before stop", 2'd1);
      b_byte(8'hFF); b_stop();
      chk_route("R3 stays registers after stop", 2'd1);
   endtask

   task automatic t_ignored();
      b_start(); b_byte(8'h72); b_byte(8'h55); b_stop();
      chk_route("R7 unknown command", 2'd1);
      chk_val("R10 opcode capture", opc, 8'h55);
      b_start(); b_byte(8'h73); b_byte(8'h02); b_stop();
      chk_route("R7 read second byte", 2'd1);
      chk_val("R10 read not captured", opc, 8'h55);
      b_start(); b_byte(8'hA0); b_byte(8'h02); b_stop();
      chk_route("R7 other address", 2'd1);
   endtask

   task automatic t_to_ddc();
      b_start(); b_byte(8'h72); b_byte(8'h02);
      chk_route("R6 no change before stop", 2'd1);
      chk_val("R10 ddc opcode", opc, 8'h02);
      sda = 1'b1; wt(HALF); scl = 1'b1; wt(HALF); sda = 1'b0; wt(HALF); scl = 1'b0; wt(HALF);
      chk_route("R9 repeated start applies nothing", 2'd1);
      b_byte(8'hA0); b_stop();
      chk_route("R6 R9 ddc after stop", 2'd2);
   endtask

   task automatic t_ddc_stay();
      scl = 1'b0; wt(HALF);
      sda = 1'b0; wt(HALF); sda = 1'b1; wt(HALF); sda = 1'b0; wt(HALF);
      scl = 1'b1; wt(HALF); sda = 1'b1; wt(2*HALF);
      chk_route("R8 R9 lone stop keeps ddc", 2'd2);
      b_start(); b_byte(8'h72);
      chk_route("R8 address not decoded", 2'd2);
      b_byte(8'h01); b_stop();
      chk_route("R8 start+stop returns", 2'd1);
   endtask

   task automatic t_to_prom();
      b_start(); b_byte(8'h72); b_byte(8'h01);
      chk_route("R6 prom waits for stop", 2'd1);
      b_stop();
      chk_route("R6 prom after stop", 2'd0);
   endtask

   task automatic t_sel_high();
      addr_sel = 1'b1; wt(2);
      b_start(); b_byte(8'h72); b_stop();
      chk_route("R4 72h with sel high", 2'd0);
      b_start(); b_byte(8'h70);
      chk_route("R4 70h with sel high", 2'd1);
      b_byte(8'h01); b_stop();
      chk_route("R6 back to prom sel high", 2'd0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_foreign();
            t_hijack();
            t_ignored();
            t_to_ddc();
            t_ddc_stay();
            t_to_prom();
            t_sel_high();
         end
         begin
            wt(150000);
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule